// File: doc/BRIEF.md
# Bridge Gate Input Router

The router takes a bank of asynchronous digital input pins and produces four active-high gate commands for the switches of a full bridge. The outputs are ordered S1, S2, S3, S4. Each switch has its own pin index and its own polarity. The pin index can point at any pin in the bank. The polarity is either active high, where a high pin turns the switch on, or active low, where a low pin turns it on.

An optional switching-enable signal also comes from a selectable pin and has its own polarity. When the enable feature is in use and the enable is inactive, the gate outputs freeze at their last values. They are not forced off. When the feature is not in use, the outputs always follow the routed, polarity-corrected pins.

The pins pass through a two-flop synchroniser, then through the routing and polarity logic, and then into a registered output stage. Configuration is captured by a load strobe and is meant to be written while the bridge is idle.

Top module: `gpr_router`

## Requirements
- R1: While reset is active and directly after it, all four gate outputs are 0. Reset also clears the configuration, so every index is 0 and every polarity bit is 0.
- R2: The 5-bit index field of a switch holds the pin number minus one. Field value v selects bit v of `pins_i`, so value 0 selects pin 1 and value 31 selects pin 32.
- R3: A polarity bit of 0 makes the gate equal to the selected pin level. A polarity bit of 1 makes the gate the inverse of that level.
- R4: `gate_o[k]` drives switch S(k+1). Its index sits in `cfg_sel_i[5k+4:5k]` and its polarity in `cfg_pol_i[k]`.
- R5: With `cfg_en_use_i` = 0 in the loaded configuration, the outputs follow the routed inputs whatever the level of the enable pin.
- R6: With the enable feature in use, the enable is active when its selected pin, after its polarity (0 means active high, 1 means active low), reads 1. While it is active, the outputs follow the routed inputs.
- R7: With the enable feature in use and the enable inactive, the gate outputs keep their previous values while the gate pins change.
- R8: A pin change driven between two clock edges reaches `gate_o` on the third rising edge after it. The first two edges are the synchroniser and the third is the output register.
- R9: A configuration presented with `cfg_load_i` = 1 at a rising edge governs the outputs from the following edge onward.
- R10: When the enable pin and the gate pins change in the same sample, the new enable level decides that update. A falling enable keeps the old gates. A rising enable applies the new gates on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pins_i | input | 32 | Asynchronous digital input pin bank (bit v is pin v+1) |
| cfg_load_i | input | 1 | Load strobe for the configuration fields |
| cfg_sel_i | input | 20 | Four 5-bit pin indices, S1 in the low field |
| cfg_pol_i | input | 4 | Per-switch polarity, 1 = active low |
| cfg_en_use_i | input | 1 | 1 = switching-enable feature in use |
| cfg_en_sel_i | input | 5 | Pin index of the enable, minus one |
| cfg_en_pol_i | input | 1 | Enable polarity, 1 = active low |
| gate_o | output | 4 | Registered active-high gate commands, S1 in bit 0 |

## Verification
The enable decision and the gate-pin routing travel through the same synchroniser. They can therefore land on the output register in the same cycle, when the enable pin and the gate pins are driven in one step. The bench provokes both orderings with directed stimulus: the enable falls while the gates change, and the enable rises while the gates change. It samples two and three edges after the drive. In the first case the old gates must survive, and in the second the new gates must appear exactly on the third edge. Random configurations can also map the enable onto one of the gate pins. The bench model then judges each update from the one shared sample of the pins.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  typedef enum logic {
    POL_ACT_HIGH = 1'b0,
    POL_ACT_LOW  = 1'b1
  } pol_e;

  // Convert a raw pin level into an "asserted" level under a polarity
  function automatic logic to_active(input logic level, input pol_e pol);
    return (pol == POL_ACT_LOW) ? ~level : level;
  endfunction

  // Enable gate: feature off means always apply
  function automatic logic may_apply(input logic use_en, input logic en_active);
    return (!use_en) || en_active;
  endfunction

endpackage

// File: rtl/gpr_sync.sv
module gpr_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  // Counts edges since reset so the delay check never looks before it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assign q_o = stage2_q;

  // R8: the synchroniser delays the pins by exactly two edges
  a_r8_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (q_o == $past(d_i, 2)));

endmodule

// File: rtl/gpr_pin_select.sv
module gpr_pin_select
  import gpr_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int NUM_SEL  = 5,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0]      pins_i,
  input  logic [NUM_SEL*IDX_W-1:0] sel_i,
  input  logic [NUM_SEL-1:0]       pol_i,
  output logic [NUM_SEL-1:0]       act_o
);

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic             raw;

    assign idx = sel_i[k*IDX_W +: IDX_W];

    // Index-driven multiplexer across the whole pin bank
    always_comb begin
      raw = 1'b0;
      for (int p = 0; p < NUM_PINS; p++) begin
        if (idx == IDX_W'(p)) raw = pins_i[p];
      end
    end

    assign act_o[k] = to_active(raw, pol_e'(pol_i[k]));
  end

endmodule

// File: rtl/gpr_gate_hold.sv
module gpr_gate_hold #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         apply_i,
  input  logic [N-1:0] next_i,
  output logic [N-1:0] gate_o
);

  logic [N-1:0] gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gate_q <= '0;
    else if (apply_i) gate_q <= next_i;
  end

  assign gate_o = gate_q;

  // R6: an applied update shows up on the next edge
  a_r6_apply_follow: assert property (@(posedge clk) disable iff (!rst_n)
    apply_i |=> (gate_o == $past(next_i)));

  // R7: without apply the gates are frozen
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_i |=> $stable(gate_o));

endmodule

// File: rtl/gpr_router.sv
module gpr_router
  import gpr_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int NUM_SW   = 4,
  localparam int IDX_W   = $clog2(NUM_PINS),
  localparam int NUM_SEL = NUM_SW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_PINS-1:0]     pins_i,
  input  logic                    cfg_load_i,
  input  logic [NUM_SW*IDX_W-1:0] cfg_sel_i,
  input  logic [NUM_SW-1:0]       cfg_pol_i,
  input  logic                    cfg_en_use_i,
  input  logic [IDX_W-1:0]        cfg_en_sel_i,
  input  logic                    cfg_en_pol_i,
  output logic [NUM_SW-1:0]       gate_o
);

  // Configuration registers
  logic [NUM_SW*IDX_W-1:0] sel_q;
  logic [NUM_SW-1:0]       pol_q;
  logic                    en_use_q;
  logic [IDX_W-1:0]        en_sel_q;
  logic                    en_pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      pol_q    <= '0;
      en_use_q <= 1'b0;
      en_sel_q <= '0;
      en_pol_q <= 1'b0;
    end else if (cfg_load_i) begin
      sel_q    <= cfg_sel_i;
      pol_q    <= cfg_pol_i;
      en_use_q <= cfg_en_use_i;
      en_sel_q <= cfg_en_sel_i;
      en_pol_q <= cfg_en_pol_i;
    end
  end

  // Synchronised pins
  logic [NUM_PINS-1:0] pins_s;

  gpr_sync #(.W(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_i),
    .q_o   (pins_s)
  );

  // Route the gate lanes and the enable lane together (enable is the top lane)
  logic [NUM_SEL-1:0] lane_act;
  logic [NUM_SW-1:0]  gate_next;
  logic               en_active;
  logic               apply_upd;

  gpr_pin_select #(.NUM_PINS(NUM_PINS), .NUM_SEL(NUM_SEL)) u_sel (
    .pins_i (pins_s),
    .sel_i  ({en_sel_q, sel_q}),
    .pol_i  ({en_pol_q, pol_q}),
    .act_o  (lane_act)
  );

  assign gate_next = lane_act[NUM_SW-1:0];
  assign en_active = lane_act[NUM_SW];
  assign apply_upd = may_apply(en_use_q, en_active);

  gpr_gate_hold #(.N(NUM_SW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .apply_i (apply_upd),
    .next_i  (gate_next),
    .gate_o  (gate_o)
  );

  // R5: with the feature off the gates track the routed lanes every edge
  a_r5_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_use_q) |=> (gate_o == $past(gate_next)));

endmodule

// File: tb/sim_gpr_router.sv
module sim_gpr_router;

  localparam int NP = 32;
  localparam int NS = 4;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          cfg_load = 1'b0;
  logic [NS*IW-1:0] cfg_sel = '0;
  logic [NS-1:0] cfg_pol = '0;
  logic          cfg_en_use = 1'b0;
  logic [IW-1:0] cfg_en_sel = '0;
  logic          cfg_en_pol = 1'b0;
  logic [NS-1:0] gate;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench-side copy of the loaded configuration and the expected gates
  logic [NS*IW-1:0] m_sel = '0;
  logic [NS-1:0]    m_pol = '0;
  logic             m_use = 1'b0;
  logic [IW-1:0]    m_esel = '0;
  logic             m_epol = 1'b0;
  logic [NS-1:0]    exp_g = '0;

  always #2 clk = ~clk;

  gpr_router u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .pins_i       (pins),
    .cfg_load_i   (cfg_load),
    .cfg_sel_i    (cfg_sel),
    .cfg_pol_i    (cfg_pol),
    .cfg_en_use_i (cfg_en_use),
    .cfg_en_sel_i (cfg_en_sel),
    .cfg_en_pol_i (cfg_en_pol),
    .gate_o       (gate)
  );

  function automatic logic [NS-1:0] f_route(input logic [NP-1:0] p,
                                            input logic [NS*IW-1:0] s,
                                            input logic [NS-1:0] pl);
    logic [NS-1:0] r;
    for (int k = 0; k < NS; k++) begin
      int v;
      v = int'(s[k*IW +: IW]);
      r[k] = pl[k] ? !p[v] : p[v];
    end
    return r;
  endfunction

  function automatic logic f_en(input logic [NP-1:0] p, input logic [IW-1:0] s,
                                input logic pl);
    return p[int'(s)] != pl;
  endfunction

  task automatic check(input string req, input logic [NS-1:0] got,
                       input logic [NS-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: gate=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic load(input logic [NS*IW-1:0] s, input logic [NS-1:0] pl,
                      input logic use_en, input logic [IW-1:0] es, input logic ep);
    @(negedge clk);
    cfg_sel = s; cfg_pol = pl; cfg_en_use = use_en; cfg_en_sel = es; cfg_en_pol = ep;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_sel = s; m_pol = pl; m_use = use_en; m_esel = es; m_epol = ep;
  endtask

  task automatic settle_model();
    repeat (4) @(negedge clk);
    if (!m_use || f_en(pins, m_esel, m_epol)) exp_g = f_route(pins, m_sel, m_pol);
  endtask

  task automatic drive(input logic [NP-1:0] p, input string req);
    @(negedge clk);
    pins = p;
    settle_model();
    check(req, gate, exp_g);
  endtask

  localparam logic [NS*IW-1:0] IDENT = {5'd3, 5'd2, 5'd1, 5'd0};

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: gate=%b expected=run to finish", gate);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    pins = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R1 during reset", gate, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", gate, 4'b0000);
    // Reset config: all lanes on pin 1, active high -> all follow pin 1
    repeat (3) @(negedge clk);
    check("R1 reset config pin1", gate, 4'b1111);
    exp_g = 4'b1111;

    // R2/R4: identity map, order S1..S4
    load(IDENT, 4'b0000, 1'b0, 5'd0, 1'b0);
    drive(32'h0000_0005, "R4 order");
    check("R2 identity literal", gate, 4'b0101);
    // R2 boundary: S1 on pin 32, S4 on pin 1
    load({5'd0, 5'd2, 5'd1, 5'd31}, 4'b0000, 1'b0, 5'd0, 1'b0);
    drive(32'h8000_0000, "R2 pin32");
    check("R2 pin32 literal", gate, 4'b0001);
    // R3: active low
    load(IDENT, 4'b1111, 1'b0, 5'd0, 1'b0);
    drive(32'h0000_0000, "R3 active low");
    check("R3 literal", gate, 4'b1111);
    load(IDENT, 4'b0101, 1'b0, 5'd0, 1'b0);
    drive(32'h0000_0003, "R3 mixed");
    check("R3 mixed literal", gate, 4'b0110);
    // R9: new config takes effect without pin change
    load(IDENT, 4'b0000, 1'b0, 5'd0, 1'b0);
    @(negedge clk);
    check("R9 config applied", gate, 4'b0011);
    exp_g = 4'b0011;

    // R8: exact latency
    @(negedge clk); pins = 32'h0000_000C;
    @(negedge clk); check("R8 edge1", gate, 4'b0011);
    @(negedge clk); check("R8 edge2", gate, 4'b0011);
    @(negedge clk); check("R8 edge3", gate, 4'b1100);
    exp_g = 4'b1100;

    // R6/R7: enable on pin 11, active high
    load(IDENT, 4'b0000, 1'b1, 5'd10, 1'b0);
    drive(32'h0000_0401, "R6 enabled follow");
    check("R6 literal", gate, 4'b0001);
    drive(32'h0000_0001, "R7 enable drop");
    drive(32'h0000_000E, "R7 hold");
    check("R7 held literal", gate, 4'b0001);
    // R6 with active-low enable: pin 11 low is active
    load(IDENT, 4'b0000, 1'b1, 5'd10, 1'b1);
    settle_model();
    check("R6 active-low enable", gate, 4'b1110);
    // R5: feature off ignores enable pin
    load(IDENT, 4'b0000, 1'b0, 5'd10, 1'b0);
    drive(32'h0000_0009, "R5 bypass");
    check("R5 literal", gate, 4'b1001);

    // R10: enable and gates change in the same sample (enable on pin 5)
    load(IDENT, 4'b0000, 1'b1, 5'd4, 1'b0);
    drive(32'h0000_0013, "R10 setup");
    check("R10 setup literal", gate, 4'b0011);
    @(negedge clk); pins = 32'h0000_000C;
    repeat (3) @(negedge clk);
    check("R10 falling enable keeps", gate, 4'b0011);
    @(negedge clk); pins = 32'h0000_0015;
    @(negedge clk); @(negedge clk);
    check("R10 rising enable edge2", gate, 4'b0011);
    @(negedge clk);
    check("R10 rising enable edge3", gate, 4'b0101);
    exp_g = 4'b0101;

    // Random configurations and pins
    for (int it = 0; it < 60; it++) begin
      logic [NS*IW-1:0] rs;
      logic [NS-1:0] rp;
      logic ru, rep;
      logic [IW-1:0] res;
      rs = NS*IW'($urandom);
      rp = NS'($urandom);
      ru = 1'($urandom);
      res = IW'($urandom);
      rep = 1'($urandom);
      load(rs, rp, ru, res, rep);
      settle_model();
      check("R9 random config", gate, exp_g);
      drive($urandom, ru ? "R6 R7 random" : "R5 R2 R3 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule